// File: doc/BRIEF.md
# SPI Flash Execute-in-Place Fetch Sequencer

This block turns a word fetch from a system bus into the read transaction that a serial NOR flash needs so that code can run straight out of it. When `ready` is high, a one-cycle `req` starts a transaction with `req_addr` and the settings present on the `cfg_*` inputs. All of those settings are captured at that point. The transaction runs through four phases: an 8-bit opcode, a 24- or 32-bit address, an optional mode/dummy phase and a 32-bit data phase. The command, address and data phases each choose one, two or four lanes of their own. The mode phase uses the address lane count.

The block does not make the serial clock. A separate timing block drives `spi_step` high for one system clock for each serial clock period. Each step uses up one beat of the current phase. The output lanes and their enables change only after a step. Once the last data beat is in, the four received bytes come out on `rdata` with a one-cycle `rvalid`, and chip select is released. A send-once setting drops the opcode after the first command has gone out. A lane code of 3 in any phase rejects the request.

Top module: `xip_fetch_seq`

## Requirements
- R1: After reset, `cs_n` is 1, `io_oe` is 0, `rvalid` and `err` are 0 and `ready` is 1.
- R2: An accepted request pulls `cs_n` low in the next cycle and sends `cfg_opcode` most significant bit first. Lane code 0 uses 1 lane (8 beats), code 1 uses 2 lanes (4 beats) and code 2 uses 4 lanes (2 beats). A beat's k bits go out on `io_do[k-1:0]` with the earliest bit on the highest of those lanes, and `io_oe[k-1:0]` is all ones.
- R3: The address phase sends `req_addr[23:0]` (24 bits) when `cfg_addr4` is 0, or all 32 bits when it is 1. It goes most significant bit first, uses the address lane count and follows the lane mapping of R2.
- R4: The mode phase lasts `cfg_mode_clks` beats, and lasts none when that value is 0. Each beat takes the next k (address lane count) bits from the top of `cfg_mode_data`, with the matching bits of `cfg_mode_oe` as lane enables (1 drives, 0 floats). Beats past bit 0 float every lane.
- R5: The data phase takes 32 bits at the data lane count. It samples `io_di[1]` for 1 lane, `io_di[1:0]` for 2 lanes and `io_di[3:0]` for 4 lanes, with the earliest bit on the highest lane. `io_oe` is 0 for the whole phase.
- R6: Each received byte is assembled most significant bit first. The first byte lands in `rdata[7:0]` and the fourth in `rdata[31:24]`. `rvalid` pulses for exactly one cycle, the cycle right after the step that took the last data beat, and `cs_n` is 1 in that same cycle.
- R7: With `cfg_cmd_once` at 1 and a command phase already completed since reset, a transaction starts directly with the address. With it at 0, the opcode is always sent.
- R8: If any of the three lane codes is 3 when `req` is sampled, `err` is 1 for the next cycle. `cs_n` then stays 1 and no `rvalid` follows.
- R9: While `cs_n` is 0, `io_do` and `io_oe` hold in any cycle whose `spi_step` is 0. Exactly one beat is used up per step.
- R10: `io_oe` is 0 whenever `cs_n` is 1. `ready` is 0 during a transaction, and `req` is ignored while it is 0.
- R11: Changes to any `cfg_*` input or `req_addr` after acceptance have no effect on the running transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Fetch request, taken when `ready` is 1 |
| req_addr | input | 32 | Flash byte address |
| ready | output | 1 | Idle and able to accept a request |
| rvalid | output | 1 | One-cycle pulse: `rdata` is valid |
| rdata | output | 32 | Assembled word, first byte in bits 7:0 |
| err | output | 1 | One-cycle pulse: request rejected for an invalid lane code |
| cfg_opcode | input | 8 | Read opcode |
| cfg_cmd_lanes | input | 2 | Command lane code (0:1, 1:2, 2:4, 3:invalid) |
| cfg_addr_lanes | input | 2 | Address and mode lane code |
| cfg_data_lanes | input | 2 | Data lane code |
| cfg_addr4 | input | 1 | 1 selects a 32-bit address, 0 a 24-bit one |
| cfg_mode_clks | input | 4 | Number of mode/dummy beats |
| cfg_mode_data | input | 16 | Mode bits, sent from the top down |
| cfg_mode_oe | input | 16 | Per-bit drive enable for the mode bits |
| cfg_cmd_once | input | 1 | Send the opcode only on the first transaction |
| spi_step | input | 1 | One serial clock period has elapsed |
| cs_n | output | 1 | Flash chip select, active low |
| io_do | output | 4 | Lane output data |
| io_oe | output | 4 | Lane output enables |
| io_di | input | 4 | Lane input data |

## Verification
The assertions watch, on every cycle, the properties that do not depend on configuration. Lanes float when chip select is high or data is being received. The lanes hold still between steps. `rvalid` is a single pulse with chip select already released. A rejected request never opens a transaction. The bench's scenarios are the only evidence for the beat-by-beat bit order in each lane mode, for the way mode bits run out into floating lanes, for byte placement in the returned word, for the opcode being dropped under send-once, and for settings being frozen when a request is accepted.

// File: rtl/xip_pkg.sv
// Shared types for the execute-in-place fetch sequencer.
// Assumes four physical data lanes; lane codes 0/1/2 select 1/2/4 lanes.
package xip_pkg;

    localparam int IO_LANES = 4;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_CMD  = 3'd1,
        PH_ADDR = 3'd2,
        PH_MODE = 3'd3,
        PH_DATA = 3'd4
    } phase_e;

    typedef logic [1:0] lanes_t;

    localparam lanes_t LANES_BAD = 2'd3;

    // Moves the top k bits of a nibble onto lanes k-1..0, highest bit on the highest lane.
    function automatic logic [IO_LANES-1:0] lane_place(input logic [IO_LANES-1:0] top,
                                                       input lanes_t code);
        case (code)
            2'd0:    return {3'b000, top[3]};
            2'd1:    return {2'b00, top[3:2]};
            default: return top;
        endcase
    endfunction

endpackage

// File: rtl/xip_seq_fsm.sv
// Phase sequencer: accepts requests, rejects invalid lane codes, counts beats
// per phase on each spi_step and walks CMD -> ADDR -> MODE -> DATA -> IDLE.
// Assumes spi_step is a one-cycle strobe from an external serial clock timer.
module xip_seq_fsm
    import xip_pkg::*;
#(
    parameter int OPC_W  = 8,
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int MCLK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              spi_step,
    input  lanes_t            cmd_w_in,
    input  lanes_t            addr_w_in,
    input  lanes_t            data_w_in,
    input  logic              addr4_in,
    input  logic [MCLK_W-1:0] mclks_in,
    input  logic              once_in,
    output phase_e            phase,
    output logic              accept,
    output logic              adv,
    output logic              last_beat,
    output lanes_t            cmd_w,
    output lanes_t            addr_w,
    output lanes_t            data_w,
    output logic              err
);

    localparam int MAXB   = (ADDR_W > WORD_W) ? ADDR_W : WORD_W;
    localparam int CNT_B  = $clog2(MAXB + 1);
    localparam int CNT_W  = (CNT_B > MCLK_W) ? CNT_B : MCLK_W;

    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  beats;
    logic [MCLK_W-1:0] mclks;
    logic              addr4;
    logic              cmd_sent;
    logic              bad_code;
    phase_e            nxt;

    // Flags a request whose lane codes cannot be honoured.
    always_comb begin
        bad_code = (cmd_w_in == LANES_BAD) || (addr_w_in == LANES_BAD) ||
                   (data_w_in == LANES_BAD);
    end

    assign accept = (phase == PH_IDLE) && req && !bad_code;
    assign adv    = (phase != PH_IDLE) && spi_step;

    // Beat count of the current phase from its bit count and lane count.
    always_comb begin
        case (phase)
            PH_CMD:  beats = CNT_W'(OPC_W) >> cmd_w;
            PH_ADDR: beats = (addr4 ? CNT_W'(ADDR_W) : CNT_W'(ADDR_W - 8)) >> addr_w;
            PH_MODE: beats = CNT_W'(mclks);
            PH_DATA: beats = CNT_W'(WORD_W) >> data_w;
            default: beats = '0;
        endcase
    end

    assign last_beat = (cnt == beats - CNT_W'(1));

    // Phase that follows the current one.
    always_comb begin
        case (phase)
            PH_CMD:  nxt = PH_ADDR;
            PH_ADDR: nxt = (mclks != '0) ? PH_MODE : PH_DATA;
            PH_MODE: nxt = PH_DATA;
            default: nxt = PH_IDLE;
        endcase
    end

    // Phase register, beat counter, latched settings and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            err      <= 1'b0;
            cmd_sent <= 1'b0;
            cmd_w    <= '0;
            addr_w   <= '0;
            data_w   <= '0;
            addr4    <= 1'b0;
            mclks    <= '0;
        end else begin
            err <= 1'b0;
            if (phase == PH_IDLE) begin
                if (req && bad_code) begin
                    err <= 1'b1;
                end else if (accept) begin
                    cmd_w  <= cmd_w_in;
                    addr_w <= addr_w_in;
                    data_w <= data_w_in;
                    addr4  <= addr4_in;
                    mclks  <= mclks_in;
                    cnt    <= '0;
                    phase  <= (once_in && cmd_sent) ? PH_ADDR : PH_CMD;
                end
            end else if (spi_step) begin
                if (last_beat) begin
                    cnt   <= '0;
                    phase <= nxt;
                    if (phase == PH_CMD) cmd_sent <= 1'b1;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/xip_tx_lanes.sv
// Transmit side: holds the opcode, address and mode shift registers loaded
// at acceptance and drives lane data and enables for CMD, ADDR and MODE.
// Assumes OPC_W and MODE_W are at least 4 and ADDR_W is at least 9.
module xip_tx_lanes
    import xip_pkg::*;
#(
    parameter int OPC_W  = 8,
    parameter int ADDR_W = 32,
    parameter int MODE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept,
    input  logic                adv,
    input  phase_e              phase,
    input  lanes_t              cmd_w,
    input  lanes_t              addr_w,
    input  logic [OPC_W-1:0]    opcode,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                addr4,
    input  logic [MODE_W-1:0]   mode_data,
    input  logic [MODE_W-1:0]   mode_oe,
    output logic [IO_LANES-1:0] io_do,
    output logic [IO_LANES-1:0] io_oe
);

    logic [OPC_W-1:0]  cmd_sr;
    logic [ADDR_W-1:0] addr_sr;
    logic [MODE_W-1:0] md_sr;
    logic [MODE_W-1:0] moe_sr;

    // Loads all shift registers at acceptance and shifts the active one per beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_sr  <= '0;
            addr_sr <= '0;
            md_sr   <= '0;
            moe_sr  <= '0;
        end else if (accept) begin
            cmd_sr  <= opcode;
            addr_sr <= addr4 ? addr : {addr[ADDR_W-9:0], 8'h00};
            md_sr   <= mode_data;
            moe_sr  <= mode_oe;
        end else if (adv) begin
            case (phase)
                PH_CMD:  cmd_sr  <= cmd_sr << (1 << cmd_w);
                PH_ADDR: addr_sr <= addr_sr << (1 << addr_w);
                PH_MODE: begin
                    md_sr  <= md_sr << (1 << addr_w);
                    moe_sr <= moe_sr << (1 << addr_w);
                end
                default: ;
            endcase
        end
    end

    // Places the top bits of the active register on the lanes.
    always_comb begin
        io_do = '0;
        io_oe = '0;
        case (phase)
            PH_CMD: begin
                io_oe = lane_place(4'hF, cmd_w);
                io_do = lane_place(cmd_sr[OPC_W-1 -: 4], cmd_w);
            end
            PH_ADDR: begin
                io_oe = lane_place(4'hF, addr_w);
                io_do = lane_place(addr_sr[ADDR_W-1 -: 4], addr_w);
            end
            PH_MODE: begin
                io_oe = lane_place(moe_sr[MODE_W-1 -: 4], addr_w);
                io_do = lane_place(md_sr[MODE_W-1 -: 4], addr_w) & io_oe;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/xip_rx_pack.sv
// Receive side: shifts lane input in during the data phase and, on the last
// beat, publishes the word with the first byte received in the low byte.
// Assumes WORD_W is a multiple of 8 and at least 8.
module xip_rx_pack
    import xip_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv,
    input  phase_e              phase,
    input  logic                last_beat,
    input  lanes_t              data_w,
    input  logic [IO_LANES-1:0] io_di,
    output logic                rvalid,
    output logic [WORD_W-1:0]   rdata
);

    localparam int NBYTES = WORD_W / 8;

    logic [WORD_W-1:0] rx_sr;
    logic [WORD_W-1:0] rx_nxt;
    logic [WORD_W-1:0] packed_w;

    // Next shift value with this beat's lanes appended.
    always_comb begin
        case (data_w)
            2'd0:    rx_nxt = {rx_sr[WORD_W-2:0], io_di[1]};
            2'd1:    rx_nxt = {rx_sr[WORD_W-3:0], io_di[1:0]};
            default: rx_nxt = {rx_sr[WORD_W-5:0], io_di[3:0]};
        endcase
    end

    // Byte reversal: earliest byte (top of the shifter) goes to the bottom.
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        assign packed_w[8*i +: 8] = rx_nxt[WORD_W-8-8*i +: 8];
    end

    // Captures data beats and issues the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sr  <= '0;
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= 1'b0;
            if (adv && phase == PH_DATA) begin
                rx_sr <= rx_nxt;
                if (last_beat) begin
                    rdata  <= packed_w;
                    rvalid <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/xip_fetch_seq.sv
// Top of the execute-in-place fetch sequencer: ties the phase sequencer, the
// transmit lane driver and the receive packer together.
// Assumes an external block paces serial clocks through spi_step.
module xip_fetch_seq
    import xip_pkg::*;
#(
    parameter int OPC_W  = 8,
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int MODE_W = 16,
    parameter int MCLK_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic [ADDR_W-1:0]   req_addr,
    output logic                ready,
    output logic                rvalid,
    output logic [WORD_W-1:0]   rdata,
    output logic                err,
    input  logic [OPC_W-1:0]    cfg_opcode,
    input  logic [1:0]          cfg_cmd_lanes,
    input  logic [1:0]          cfg_addr_lanes,
    input  logic [1:0]          cfg_data_lanes,
    input  logic                cfg_addr4,
    input  logic [MCLK_W-1:0]   cfg_mode_clks,
    input  logic [MODE_W-1:0]   cfg_mode_data,
    input  logic [MODE_W-1:0]   cfg_mode_oe,
    input  logic                cfg_cmd_once,
    input  logic                spi_step,
    output logic                cs_n,
    output logic [IO_LANES-1:0] io_do,
    output logic [IO_LANES-1:0] io_oe,
    input  logic [IO_LANES-1:0] io_di
);

    phase_e phase;
    logic   accept;
    logic   adv;
    logic   last_beat;
    lanes_t cmd_w;
    lanes_t addr_w;
    lanes_t data_w;

    assign ready = (phase == PH_IDLE);
    assign cs_n  = (phase == PH_IDLE);

    xip_seq_fsm #(
        .OPC_W (OPC_W),
        .ADDR_W(ADDR_W),
        .WORD_W(WORD_W),
        .MCLK_W(MCLK_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .spi_step (spi_step),
        .cmd_w_in (cfg_cmd_lanes),
        .addr_w_in(cfg_addr_lanes),
        .data_w_in(cfg_data_lanes),
        .addr4_in (cfg_addr4),
        .mclks_in (cfg_mode_clks),
        .once_in  (cfg_cmd_once),
        .phase    (phase),
        .accept   (accept),
        .adv      (adv),
        .last_beat(last_beat),
        .cmd_w    (cmd_w),
        .addr_w   (addr_w),
        .data_w   (data_w),
        .err      (err)
    );

    xip_tx_lanes #(
        .OPC_W (OPC_W),
        .ADDR_W(ADDR_W),
        .MODE_W(MODE_W)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .adv      (adv),
        .phase    (phase),
        .cmd_w    (cmd_w),
        .addr_w   (addr_w),
        .opcode   (cfg_opcode),
        .addr     (req_addr),
        .addr4    (cfg_addr4),
        .mode_data(cfg_mode_data),
        .mode_oe  (cfg_mode_oe),
        .io_do    (io_do),
        .io_oe    (io_oe)
    );

    xip_rx_pack #(
        .WORD_W(WORD_W)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .phase    (phase),
        .last_beat(last_beat),
        .data_w   (data_w),
        .io_di    (io_di),
        .rvalid   (rvalid),
        .rdata    (rdata)
    );

endmodule

// File: rtl/xip_fetch_seq_chk.sv
// Protocol checker for the fetch sequencer, attached by bind.
module xip_fetch_seq_chk
    import xip_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                cs_n,
    input logic                spi_step,
    input logic                rvalid,
    input logic                err,
    input logic [IO_LANES-1:0] io_do,
    input logic [IO_LANES-1:0] io_oe,
    input phase_e              phase
);

    // R10
    idle_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (io_oe == '0));

    // R5
    data_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA) |-> (io_oe == '0));

    // R6
    done_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> cs_n);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);

    // R8
    reject_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (cs_n && !rvalid));

    // R9
    step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !spi_step) |=> ($stable(io_do) && $stable(io_oe) && $stable(cs_n)));

endmodule

bind xip_fetch_seq xip_fetch_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .spi_step(spi_step),
    .rvalid  (rvalid),
    .err     (err),
    .io_do   (io_do),
    .io_oe   (io_oe),
    .phase   (phase)
);

// File: tb/tb_xip_fetch_seq.sv
`timescale 1ns/1ps
module tb_xip_fetch_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [31:0] req_addr = '0;
    logic        ready, rvalid, err, cs_n;
    logic [31:0] rdata;
    logic [7:0]  cfg_opcode = 8'h03;
    logic [1:0]  cfg_cmd_lanes = 2'd0, cfg_addr_lanes = 2'd0, cfg_data_lanes = 2'd0;
    logic        cfg_addr4 = 1'b0;
    logic [3:0]  cfg_mode_clks = 4'd0;
    logic [15:0] cfg_mode_data = '0, cfg_mode_oe = '0;
    logic        cfg_cmd_once = 1'b0;
    logic        spi_step = 1'b0;
    logic [3:0]  io_do, io_oe;
    logic [3:0]  io_di = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit sent_model = 1'b0;
    bit finished = 1'b0;
    logic [31:0] exp_q[$];

    always #10 clk = ~clk;

    xip_fetch_seq dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr), .ready(ready),
        .rvalid(rvalid), .rdata(rdata), .err(err), .cfg_opcode(cfg_opcode),
        .cfg_cmd_lanes(cfg_cmd_lanes), .cfg_addr_lanes(cfg_addr_lanes),
        .cfg_data_lanes(cfg_data_lanes), .cfg_addr4(cfg_addr4),
        .cfg_mode_clks(cfg_mode_clks), .cfg_mode_data(cfg_mode_data),
        .cfg_mode_oe(cfg_mode_oe), .cfg_cmd_once(cfg_cmd_once), .spi_step(spi_step),
        .cs_n(cs_n), .io_do(io_do), .io_oe(io_oe), .io_di(io_di)
    );

    task automatic check(input bit ok, input string rq, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic int lanes(input logic [1:0] c);
        return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [3:0] lmask(input int k);
        return 4'((1 << k) - 1);
    endfunction

    // Monitor: pops the scoreboard whenever a word completes.
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            check(exp_q.size() > 0, "R6 rvalid without pending fetch", 32'd1, 32'd0);
            if (exp_q.size() > 0) begin
                logic [31:0] e;
                e = exp_q.pop_front();
                check(rdata == e, "R6 byte packing of rdata", rdata, e);
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        sent_model = 1'b0;
    endtask

    // Driver: builds the expected beats and word, then plays the flash side.
    task automatic run_txn(input logic [31:0] a, input logic [31:0] stream,
                           input int gap, input bit mutate, input bit poke);
        logic [3:0] e_do [64];
        logic [3:0] e_oe [64];
        int ntx, ncmd, nadr, k, kd, nb, total, b, it, pos;
        logic [31:0] aval;
        bit send, have_prev;
        logic [3:0] prev_do, prev_oe, g;
        logic [7:0] s_opc; logic [1:0] s_cw, s_aw, s_dw; logic s_a4; logic [3:0] s_mc;
        ntx = 0;
        send = !(cfg_cmd_once && sent_model);
        if (send) begin
            k = lanes(cfg_cmd_lanes);
            for (int j = 0; j < 8 / k; j++) begin
                e_do[ntx] = 4'((32'(cfg_opcode) >> (8 - k * (j + 1))) & 32'(lmask(k)));
                e_oe[ntx] = lmask(k);
                ntx++;
            end
        end
        ncmd = ntx;
        nb   = cfg_addr4 ? 32 : 24;
        aval = cfg_addr4 ? a : {8'h00, a[23:0]};
        k    = lanes(cfg_addr_lanes);
        for (int j = 0; j < nb / k; j++) begin
            e_do[ntx] = 4'((aval >> (nb - k * (j + 1))) & 32'(lmask(k)));
            e_oe[ntx] = lmask(k);
            ntx++;
        end
        nadr = ntx;
        for (int j = 0; j < int'(cfg_mode_clks); j++) begin
            pos = 16 - k * (j + 1);
            if (pos >= 0) begin
                e_oe[ntx] = 4'((32'(cfg_mode_oe) >> pos) & 32'(lmask(k)));
                e_do[ntx] = 4'((32'(cfg_mode_data) >> pos) & 32'(lmask(k))) & e_oe[ntx];
            end else begin
                e_oe[ntx] = 4'h0;
                e_do[ntx] = 4'h0;
            end
            ntx++;
        end
        kd    = lanes(cfg_data_lanes);
        total = ntx + 32 / kd;
        exp_q.push_back({stream[7:0], stream[15:8], stream[23:16], stream[31:24]});
        if (send) sent_model = 1'b1;
        s_opc = cfg_opcode; s_cw = cfg_cmd_lanes; s_aw = cfg_addr_lanes;
        s_dw = cfg_data_lanes; s_a4 = cfg_addr4; s_mc = cfg_mode_clks;

        @(negedge clk);
        req_addr = a;
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        check(cs_n == 1'b0, "R2 cs_n low after acceptance", 32'(cs_n), 32'd0);
        check(ready == 1'b0, "R10 ready low while busy", 32'(ready), 32'd0);
        if (mutate) begin
            // R11: scramble every setting after acceptance
            cfg_opcode = ~s_opc;
            cfg_cmd_lanes = (s_cw == 2'd2) ? 2'd0 : s_cw + 2'd1;
            cfg_addr_lanes = (s_aw == 2'd2) ? 2'd0 : s_aw + 2'd1;
            cfg_data_lanes = (s_dw == 2'd2) ? 2'd0 : s_dw + 2'd1;
            cfg_addr4 = ~s_a4;
            cfg_mode_clks = s_mc ^ 4'hF;
            req_addr = ~a;
        end
        b = 0; it = 0; have_prev = 1'b0;
        while (b < total) begin
            spi_step = ((it % gap) == 0);
            req = (poke && b == 3);
            if (spi_step) begin
                if (have_prev) begin
                    check(io_do == prev_do && io_oe == prev_oe, "R9 lanes held between steps",
                          {24'h0, io_oe, io_do}, {24'h0, prev_oe, prev_do});
                end
                if (b < ntx) begin
                    string t;
                    t = (b < ncmd) ? "R2 command beat" : (b < nadr) ? "R3 address beat" :
                                                                       "R4 mode beat";
                    if (mutate) t = {t, " (R11 settings frozen)"};
                    check(io_oe == e_oe[b], t, 32'(io_oe), 32'(e_oe[b]));
                    check((io_do & io_oe) == e_do[b], t, 32'(io_do & io_oe), 32'(e_do[b]));
                end else begin
                    check(io_oe == 4'h0, "R5 lanes float in data phase", 32'(io_oe), 32'd0);
                    g = 4'((stream >> (32 - kd * (b - ntx + 1))) & 32'(lmask(kd)));
                    case (kd)
                        1:       io_di = {2'b00, g[0], 1'b0};
                        2:       io_di = {2'b00, g[1:0]};
                        default: io_di = g;
                    endcase
                end
                b++;
                have_prev = 1'b0;
            end else begin
                prev_do = io_do;
                prev_oe = io_oe;
                have_prev = 1'b1;
            end
            it++;
            @(negedge clk);
        end
        spi_step = 1'b0;
        req = 1'b0;
        check(rvalid == 1'b1, "R6 rvalid after last data step", 32'(rvalid), 32'd1);
        check(cs_n == 1'b1, "R6 cs_n released with rvalid", 32'(cs_n), 32'd1);
        if (mutate) begin
            cfg_opcode = s_opc; cfg_cmd_lanes = s_cw; cfg_addr_lanes = s_aw;
            cfg_data_lanes = s_dw; cfg_addr4 = s_a4; cfg_mode_clks = s_mc;
        end
        if (poke) begin
            for (int j = 0; j < 3; j++) begin
                @(negedge clk);
                check(cs_n == 1'b1 && ready == 1'b1, "R10 request during busy ignored",
                      {31'h0, cs_n}, 32'd1);
            end
        end
    endtask

    task automatic bad_txn(input string tag);
        @(negedge clk);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        check(err == 1'b1, {"R8 err pulse ", tag}, 32'(err), 32'd1);
        check(cs_n == 1'b1, {"R8 no transaction ", tag}, 32'(cs_n), 32'd1);
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            check(err == 1'b0 && cs_n == 1'b1, {"R8 stays idle ", tag},
                  {30'h0, err, cs_n}, 32'd1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R1
        check(cs_n == 1'b1 && io_oe == 4'h0, "R1 reset lanes idle", {27'h0, io_oe, cs_n}, 32'd1);
        check(rvalid == 1'b0 && err == 1'b0 && ready == 1'b1, "R1 reset handshake",
              {29'h0, rvalid, err, ready}, 32'd1);

        // Single lane everywhere, 24-bit address (top byte ignored), R10 poke mid-transfer
        cfg_opcode = 8'h03; cfg_cmd_lanes = 2'd0; cfg_addr_lanes = 2'd0; cfg_data_lanes = 2'd0;
        cfg_addr4 = 1'b0; cfg_mode_clks = 4'd0;
        run_txn(32'hFFA5C3F1, 32'h11223344, 1, 1'b0, 1'b1);

        // Quad everywhere, 32-bit address, 6 mode beats run past 16 bits, paced steps
        cfg_opcode = 8'hEB; cfg_cmd_lanes = 2'd2; cfg_addr_lanes = 2'd2; cfg_data_lanes = 2'd2;
        cfg_addr4 = 1'b1; cfg_mode_clks = 4'd6; cfg_mode_data = 16'hA5F0; cfg_mode_oe = 16'hFF0F;
        run_txn(32'h12345678, 32'hDEADBEEF, 2, 1'b0, 1'b0);

        // Mixed lanes, dual mode beats, settings scrambled after acceptance
        cfg_opcode = 8'hBB; cfg_cmd_lanes = 2'd0; cfg_addr_lanes = 2'd1; cfg_data_lanes = 2'd1;
        cfg_addr4 = 1'b0; cfg_mode_clks = 4'd3; cfg_mode_data = 16'hC3C3; cfg_mode_oe = 16'h0FFF;
        run_txn(32'h00ABCDEF, 32'h5A6B7C8D, 1, 1'b1, 1'b0);

        // Dual command, quad address, single data, no mode phase, paced steps
        cfg_opcode = 8'h6C; cfg_cmd_lanes = 2'd1; cfg_addr_lanes = 2'd2; cfg_data_lanes = 2'd0;
        cfg_addr4 = 1'b1; cfg_mode_clks = 4'd0;
        run_txn(32'h80000001, 32'hF00FA55A, 3, 1'b0, 1'b0);

        // R8 invalid lane codes
        cfg_data_lanes = 2'd3;
        bad_txn("data code 3");
        cfg_data_lanes = 2'd0; cfg_cmd_lanes = 2'd3;
        bad_txn("command code 3");
        cfg_cmd_lanes = 2'd0; cfg_addr_lanes = 2'd3;
        bad_txn("address code 3");
        cfg_addr_lanes = 2'd0;

        // R7 send-once: first sends the opcode, next starts at the address
        do_reset();
        cfg_cmd_once = 1'b1; cfg_opcode = 8'h0B; cfg_mode_clks = 4'd2;
        cfg_cmd_lanes = 2'd0; cfg_addr_lanes = 2'd2; cfg_data_lanes = 2'd2; cfg_addr4 = 1'b0;
        cfg_mode_data = 16'hF000; cfg_mode_oe = 16'hFF00;
        run_txn(32'h00001234, 32'h01020304, 1, 1'b0, 1'b0);
        run_txn(32'h00005678, 32'hCAFEF00D, 1, 1'b0, 1'b0);
        cfg_cmd_once = 1'b0;
        run_txn(32'h00009ABC, 32'h13579BDF, 1, 1'b0, 1'b0);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R6 every fetch completed", exp_q.size(), 32'd0);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule